// File: doc/BRIEF.md
# Vector and Matrix Address Walker

This block turns a short request into a stream of accelerator word addresses. One word holds one complex number. The block walks three shapes: a vector, a full matrix stored column by column, and a packed upper-triangular square matrix. A request gives a base word address, a row count, a column count, a shape select and a one-cycle start pulse.

The block then offers one address per cycle on a valid/ready handshake. Each address comes with its row index i and column index j. A done pulse follows the final accepted address. Each address also appears as a byte address in the system view, and a select input chooses the real or the imaginary half of the complex word.

For the triangular shape, the offset of each column grows by one more than the column index whenever the column advances. This produces the triangular-number sequence with no multiplier. A request whose shape cannot be walked is refused with an error pulse and produces no addresses.

Top module: `vecmat_addr_gen`

## Requirements
- R1: During and right after reset, `out_valid`, `done` and `err` are low.
- R2: With `walk_mode` = 0 (vector), the block emits `n_dim` addresses `base_addr + i` for i = 0 .. n_dim-1, with `idx_j` = 0. `m_dim` is ignored in this mode.
- R3: With `walk_mode` = 1 (full matrix), the block emits `m_dim*n_dim` addresses `base_addr + j*m_dim + i`. The index i runs fastest, from 0 to m_dim-1, and j runs from 0 to n_dim-1.
- R4: With `walk_mode` = 2 (packed upper-triangular), the block emits exactly n_dim(n_dim+1)/2 addresses `base_addr + j(j+1)/2 + i`. Within column j, i runs from 0 to j, and `idx_i` never exceeds `idx_j`.
- R5: `byte_addr` always equals `word_addr*8 + 4*imag_sel`. This means bit 2 carries the imaginary select and bits 1:0 are zero.
- R6: While `out_valid` is high and `out_ready` is low, the block holds `out_valid`, `word_addr`, `idx_i` and `idx_j` unchanged into the next cycle.
- R7: `done` is high for exactly the one cycle after the final address is accepted. In that same cycle `out_valid` is low.
- R8: A start is refused in four cases: `n_dim` is zero in any shape, `m_dim` is zero in full-matrix mode, `m_dim` differs from `n_dim` in triangular mode, or `walk_mode` is 3. A refused start pulses `err` for one cycle, in the cycle after the start, and no address is emitted.
- R9: A start pulse that arrives while a walk is in progress has no effect on that walk.
- R10: Word addresses wrap modulo 2^AW.
- R11: The first address appears with `out_valid` high in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| walk_mode | input | 2 | 0 vector, 1 full matrix, 2 upper-triangular, 3 reserved |
| base_addr | input | AW | First word address of the object |
| m_dim | input | DW | Row count |
| n_dim | input | DW | Column count (vector length in vector mode) |
| imag_sel | input | 1 | Byte address points at imaginary half when high |
| out_ready | input | 1 | Consumer accepts the offered address |
| out_valid | output | 1 | An address is offered |
| word_addr | output | AW | Accelerator word address |
| byte_addr | output | AW+3 | System byte address of the selected half |
| idx_i | output | DW | Row index of the offered element |
| idx_j | output | DW | Column index of the offered element |
| done | output | 1 | Pulse after the final accepted address |
| err | output | 1 | Pulse after a refused start |

## Verification
The assertions assume that `out_ready` is a plain level the consumer may change in any cycle. They also assume that request fields matter only in the cycle of an accepted start. They do not assume that start is withheld while busy. The bench therefore fires a start in the middle of a walk and checks that the stream is unaffected. The bench sweeps every vector length up to 7, every full shape up to 4 by 4 and every triangle up to 6 by 6. It uses a deterministic stall pattern on `out_ready` and keeps all other inputs steady between starts.

// File: rtl/vmag_pkg.sv
package vmag_pkg;

   typedef enum logic [1:0] {
      WALK_VEC  = 2'd0,
      WALK_FULL = 2'd1,
      WALK_TRI  = 2'd2,
      WALK_RSVD = 2'd3
   } walk_mode_t;

   // request check shared by controller and any wrapper
   function automatic logic req_ok(input walk_mode_t md, input logic m_zero,
                                   input logic n_zero, input logic m_eq_n);
      case (md)
         WALK_VEC:  req_ok = !n_zero;
         WALK_FULL: req_ok = !n_zero && !m_zero;
         WALK_TRI:  req_ok = !n_zero && m_eq_n;
         default:   req_ok = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/vmag_ctrl.sv
module vmag_ctrl
   import vmag_pkg::*;
#(
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  walk_mode_t    mode_in,
   input  logic [DW-1:0] m_in,
   input  logic [DW-1:0] n_in,
   input  logic          fire,
   input  logic          last,
   output logic          running,
   output logic          load,
   output logic          done,
   output logic          err
);

   logic accept_ok;
   logic refuse;

   assign accept_ok = req_ok(mode_in, (m_in == '0), (n_in == '0), (m_in == n_in));
   assign load      = start && !running && accept_ok;
   assign refuse    = start && !running && !accept_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= fire && last;
         err  <= refuse;
         if (load)
            running <= 1'b1;
         else if (fire && last)
            running <= 1'b0;
      end
   end

   // R7: done lasts one cycle and follows an accepted handshake
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(fire) && !running);
   // R8: a refused start never opens a walk
   assert_err_no_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !running && !done);
   // R11: an accepted start offers data in the next cycle
   assert_start_to_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> running);

endmodule

// File: rtl/vmag_index.sv
module vmag_index
   import vmag_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          fire,
   input  logic          active,
   input  walk_mode_t    mode_in,
   input  logic [AW-1:0] base_in,
   input  logic [DW-1:0] m_in,
   input  logic [DW-1:0] n_in,
   output logic [DW-1:0] idx_i,
   output logic [DW-1:0] idx_j,
   output logic [AW-1:0] word_addr,
   output logic          last
);

   localparam logic [DW-1:0] IDX_ONE  = DW'(1);
   localparam logic [AW-1:0] ADDR_ONE = AW'(1);

   walk_mode_t    mode_q;
   logic [AW-1:0] base_q;
   logic [AW-1:0] col_off_q;
   logic [DW-1:0] m_q, n_q, i_q, j_q;
   logic          row_end;
   logic          col_end;
   logic [AW-1:0] col_step;

   // end-of-column depends on the shape
   always_comb begin
      case (mode_q)
         WALK_VEC:  row_end = (i_q == n_q - IDX_ONE);
         WALK_FULL: row_end = (i_q == m_q - IDX_ONE);
         WALK_TRI:  row_end = (i_q == j_q);
         default:   row_end = 1'b1;
      endcase
   end

   assign col_end = (mode_q == WALK_VEC) || (j_q == n_q - IDX_ONE);
   assign last    = row_end && col_end;

   // column offset grows by M (full) or by j+1 (triangular numbers)
   always_comb begin
      case (mode_q)
         WALK_FULL: col_step = AW'(m_q);
         WALK_TRI:  col_step = AW'(j_q) + ADDR_ONE;
         default:   col_step = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= WALK_VEC;
         base_q    <= '0;
         m_q       <= '0;
         n_q       <= '0;
         i_q       <= '0;
         j_q       <= '0;
         col_off_q <= '0;
      end else if (load) begin
         mode_q    <= mode_in;
         base_q    <= base_in;
         m_q       <= m_in;
         n_q       <= n_in;
         i_q       <= '0;
         j_q       <= '0;
         col_off_q <= '0;
      end else if (fire && !last) begin
         if (row_end && mode_q != WALK_VEC) begin
            i_q       <= '0;
            j_q       <= j_q + IDX_ONE;
            col_off_q <= col_off_q + col_step;
         end else begin
            i_q <= i_q + IDX_ONE;
         end
      end
   end

   assign idx_i     = i_q;
   assign idx_j     = j_q;
   assign word_addr = base_q + col_off_q + AW'(i_q);

   // R4: triangular walk stays on or above the diagonal
   assert_tri_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active && mode_q == WALK_TRI |-> idx_i <= idx_j);
   // R3: full walk row index stays inside the column
   assert_full_row_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active && mode_q == WALK_FULL |-> idx_i < m_q);
   // R2: vector walk keeps the column index at zero
   assert_vec_col_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active && mode_q == WALK_VEC |-> idx_j == '0);
   // R3: inside a column the next address is one word further
   assert_full_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !load && mode_q == WALK_FULL && !row_end |=> word_addr == $past(word_addr) + ADDR_ONE);

endmodule

// File: rtl/vecmat_addr_gen.sv
module vecmat_addr_gen
   import vmag_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    walk_mode,
   input  logic [AW-1:0] base_addr,
   input  logic [DW-1:0] m_dim,
   input  logic [DW-1:0] n_dim,
   input  logic          imag_sel,
   input  logic          out_ready,
   output logic          out_valid,
   output logic [AW-1:0] word_addr,
   output logic [AW+2:0] byte_addr,
   output logic [DW-1:0] idx_i,
   output logic [DW-1:0] idx_j,
   output logic          done,
   output logic          err
);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("vecmat_addr_gen: AW must be at least 2");
      end
      if (DW < 1 || DW > 16) begin : g_bad_dw
         $error("vecmat_addr_gen: DW must lie in 1..16");
      end
   endgenerate

   walk_mode_t mode_in;
   logic       running, load, fire, last;

   assign mode_in = walk_mode_t'(walk_mode);
   assign fire    = running && out_ready;

   vmag_ctrl #(.DW(DW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mode_in (mode_in),
      .m_in    (m_dim),
      .n_in    (n_dim),
      .fire    (fire),
      .last    (last),
      .running (running),
      .load    (load),
      .done    (done),
      .err     (err)
   );

   vmag_index #(.AW(AW), .DW(DW)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .fire      (fire),
      .active    (running),
      .mode_in   (mode_in),
      .base_in   (base_addr),
      .m_in      (m_dim),
      .n_in      (n_dim),
      .idx_i     (idx_i),
      .idx_j     (idx_j),
      .word_addr (word_addr),
      .last      (last)
   );

   assign out_valid = running;
   // word*8 plus 4 for the imaginary half
   assign byte_addr = {word_addr, imag_sel, 2'b00};

   // R6: a stalled offer is held unchanged
   assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(word_addr) && $stable(idx_i) && $stable(idx_j));
   // R7: valid is low while done is shown
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);
   // R9: a start during a walk does not restart indices
   assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && start |=> $stable(word_addr));

endmodule

// File: tb/vecmat_addr_gen_bench.sv
module vecmat_addr_gen_bench;

   localparam int AW = 12;
   localparam int DW = 4;
   localparam int CLK_PERIOD = 10;
   localparam int AMASK = (1 << AW) - 1;
   localparam int BMASK = (1 << (AW + 3)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    walk_mode = 2'd0;
   logic [AW-1:0] base_addr = '0;
   logic [DW-1:0] m_dim = '0;
   logic [DW-1:0] n_dim = '0;
   logic          imag_sel = 1'b0;
   logic          out_ready = 1'b0;
   logic          out_valid;
   logic [AW-1:0] word_addr;
   logic [AW+2:0] byte_addr;
   logic [DW-1:0] idx_i, idx_j;
   logic          done, err;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int stall_seed = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vecmat_addr_gen #(.AW(AW), .DW(DW)) u_vecmat_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .walk_mode(walk_mode),
      .base_addr(base_addr), .m_dim(m_dim), .n_dim(n_dim), .imag_sel(imag_sel),
      .out_ready(out_ready), .out_valid(out_valid), .word_addr(word_addr),
      .byte_addr(byte_addr), .idx_i(idx_i), .idx_j(idx_j), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // mode 0 vector, 1 full, 2 triangular
   task automatic run_walk(input int md, input int base, input int m, input int n,
                           input bit imag, input bit poke);
      int cnt, k, guard, ei, ej, ea, eb, held_addr;
      bit held;
      string tag;
      cnt = (md == 0) ? n : (md == 1) ? m * n : n * (n + 1) / 2;
      tag = (md == 0) ? "R2" : (md == 1) ? "R3" : "R4";
      @(negedge clk);
      walk_mode = 2'(md); base_addr = AW'(base); m_dim = DW'(m); n_dim = DW'(n);
      imag_sel = imag; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(out_valid === 1'b1, "R11 first offer", int'(out_valid), 1);
      k = 0; guard = 0; held = 0; ei = 0; ej = 0; held_addr = 0;
      while (k < cnt && guard < 2000) begin
         guard++;
         if (start) start = 1'b0;
         if (held)
            chk(out_valid === 1'b1 && int'(word_addr) == held_addr, "R6 hold",
                int'(word_addr), held_addr);
         if (md == 0) ea = (base + k) & AMASK;
         else if (md == 1) ea = (base + (k / m) * m + (k % m)) & AMASK;
         else ea = (base + ej * (ej + 1) / 2 + ei) & AMASK;
         eb = (ea * 8 + (imag ? 4 : 0)) & BMASK;
         chk(out_valid === 1'b1 && int'(word_addr) == ea, tag, int'(word_addr), ea);
         chk(int'(byte_addr) == eb, "R5 byte", int'(byte_addr), eb);
         if (md == 1) begin
            chk(int'(idx_i) == k % m && int'(idx_j) == k / m, "R3 idx",
                int'(idx_i) * 100 + int'(idx_j), (k % m) * 100 + k / m);
         end else if (md == 2) begin
            chk(int'(idx_i) == ei && int'(idx_j) == ej, "R4 idx",
                int'(idx_i) * 100 + int'(idx_j), ei * 100 + ej);
         end else begin
            chk(int'(idx_i) == k && idx_j == '0, "R2 idx", int'(idx_i), k);
         end
         if (poke && k == 1 && !held) begin
            // R9: foreign request mid-walk
            start = 1'b1; walk_mode = 2'd1; base_addr = '0; m_dim = DW'(2); n_dim = DW'(2);
         end
         stall_seed++;
         out_ready = ((stall_seed * 7) % 5) != 0;
         held = !out_ready;
         held_addr = int'(word_addr);
         if (out_ready) begin
            k++;
            if (md == 2) begin
               if (ei == ej) begin ei = 0; ej++; end else ei++;
            end
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(k == cnt, "R7 walk length", k, cnt);
      chk(done === 1'b1 && out_valid === 1'b0, "R7 done after last",
          int'(done) * 10 + int'(out_valid), 10);
      @(negedge clk);
      chk(done === 1'b0 && out_valid === 1'b0, "R7 done one cycle",
          int'(done) * 10 + int'(out_valid), 0);
   endtask

   task automatic run_refused(input int md, input int m, input int n);
      @(negedge clk);
      walk_mode = 2'(md); m_dim = DW'(m); n_dim = DW'(n); base_addr = AW'(5); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err === 1'b1 && out_valid === 1'b0, "R8 err pulse",
          int'(err) * 10 + int'(out_valid), 10);
      @(negedge clk);
      chk(err === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R8 no walk",
          int'(err) * 100 + int'(out_valid) * 10 + int'(done), 0);
   endtask

   initial begin
      @(negedge clk);
      chk(out_valid === 1'b0 && done === 1'b0 && err === 1'b0, "R1 in reset",
          int'(out_valid) + int'(done) + int'(err), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0 && done === 1'b0 && err === 1'b0, "R1 after reset",
          int'(out_valid) + int'(done) + int'(err), 0);

      for (int n = 1; n <= 7; n++) run_walk(0, 37 * n, 9, n, n[0], 1'b0);
      for (int m = 1; m <= 4; m++)
         for (int n = 1; n <= 4; n++) run_walk(1, 100 + m * 16 + n, m, n, (m + n) % 2 == 1, 1'b0);
      for (int n = 1; n <= 6; n++) run_walk(2, 300 + n, n, n, n[1], 1'b0);

      run_walk(1, 4090, 3, 3, 1'b1, 1'b0);   // R10 wrap
      run_walk(2, 4093, 4, 4, 1'b0, 1'b0);   // R10 wrap triangular
      run_walk(1, 50, 3, 4, 1'b0, 1'b1);     // R9 start during walk
      run_walk(2, 60, 5, 5, 1'b1, 1'b1);     // R9 start during walk

      run_refused(0, 3, 0);
      run_refused(1, 0, 3);
      run_refused(1, 3, 0);
      run_refused(2, 3, 4);
      run_refused(2, 0, 0);
      run_refused(3, 2, 2);

      run_walk(0, 10, 0, 3, 1'b0, 1'b0);     // R2 m ignored in vector mode

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule